// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Word Memory

This block models a synchronous memory organised as 32-bit words (four 8-bit lanes) whose reads flow through: the word at the registered address reaches `rdata` combinationally, with no output register. An address is taken in on a rising edge through either of two strobes. One strobe is used by a processor and one by a memory controller. Both are qualified by three chip enables. A 2-bit counter then steps through the remaining words of the aligned four-word group while the step input is held low.

Writes happen on the rising edge. They cover either every lane (global write) or only the lanes picked by active-low lane selects (lane write). The data bus is split into `wdata` and `rdata`. The output-valid flag `rvalid` replaces a driven bus. It follows the asynchronous output enable. It stays low on the first cycle after the block is selected out of a deselected state.

The control is a three-state machine. In DESEL the block is deselected. MASKED is the first cycle after a load out of DESEL. LIVE means the block is selected and outputs may be enabled. The transitions are:
- LOAD_FROM_DESEL goes from DESEL to MASKED.
- UNMASK goes from MASKED to LIVE, on any load or continue cycle.
- RELOAD goes from LIVE to LIVE.
- DROP goes from MASKED or LIVE to DESEL.
- HOLD_DESEL keeps DESEL.

Top module: `fts_burst_ram`

## Requirements
- R1: A rising edge loads `addr_in` when an effective strobe is present and the chip enables are all active (`en_a_n`=0, `en_b`=1, `en_c_n`=0). An effective strobe is `ctl_strobe_n`=0, or `cpu_strobe_n`=0 with `en_a_n`=0. On the following cycle `rdata` shows the word at that address, with no extra register stage.
- R2: `cpu_strobe_n`=0 with `en_a_n`=1 has no effect. If `ctl_strobe_n` is also high, the cycle is treated as a continue cycle.
- R3: `en_b` and `en_c_n` matter only in cycles with an effective strobe. In a continue cycle, inactive values on them neither deselect the block nor stop a burst.
- R4: An effective strobe with any chip enable inactive deselects the block. While deselected, `rvalid` is 0, and step and write inputs are ignored until a new load.
- R5: `all_wr_n`=0 in a selected cycle writes all four lanes, whatever `lane_wr_n` and `lane_sel_n` hold.
- R6: When `all_wr_n`=1, `lane_wr_n`=0 writes lane k (bits 8k+7:8k) only where `lane_sel_n[k]`=0. When both `all_wr_n` and `lane_wr_n` are 1, nothing is written.
- R7: In a selected continue cycle with `step_n`=0, the low two address bits advance by one modulo 4 and the upper bits are kept (linear order, e.g. 6,7,4,5).
- R8: In the LIVE state, `rvalid` equals the inverse of `oe_n` combinationally, with no clock involved. In every other state it is 0.
- R9: In the cycle after a load out of the deselected state, `rvalid` is 0 even with `oe_n`=0.
- R10: A write on a load edge goes to the newly loaded address. A write on a stepping edge goes to the address held before the step.
- R11: Reset leaves the block deselected with `rvalid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_in | input | AW | Word address for loads |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, ignored while `en_a_n` is high |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high, sampled on strobe cycles only |
| en_c_n | input | 1 | Chip enable, active low, sampled on strobe cycles only |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write selects, active low |
| step_n | input | 1 | Burst step, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rvalid | output | 1 | Read data is being driven |

## Verification
Two pairs of functions can land on the same edge. A write can coincide with a burst step, and it must then use the address from before the step. A write can also coincide with an address load, and it must then use the new address. The bench produces both: it streams global writes while holding `step_n` low, and it issues a controller strobe with a global write. Every written word is later read back through `rdata`. A behavioural model that tracks address, state and lane contents judges each read on every clock, so a write to the wrong address or lane shows up as a data mismatch.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [1:0] {
        ST_DESEL  = 2'd0,
        ST_MASKED = 2'd1,
        ST_LIVE   = 2'd2
    } ram_state_e;
endpackage

// File: rtl/fts_burst_addr.sv
module fts_burst_addr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_go,
    input  logic          adv_go,
    input  logic [AW-1:0] load_addr,
    output logic [AW-1:0] cur_addr
);
    logic [AW-3:0] hi_q;
    logic [1:0]    lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load_go) begin
            hi_q <= load_addr[AW-1:2];
            lo_q <= load_addr[1:0];
        end else if (adv_go) begin
            lo_q <= lo_q + 2'd1;
        end
    end

    assign cur_addr = {hi_q, lo_q};
endmodule

// File: rtl/fts_lane_decode.sv
module fts_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             wr_go,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    output logic [LANES-1:0] lane_en
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_en[k] = wr_go && (!all_wr_n || (!lane_wr_n && !lane_sel_n[k]));
    end
endmodule

// File: rtl/fts_word_store.sv
module fts_word_store #(
    parameter int WORDS  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int AW = $clog2(WORDS),
    localparam int DW = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] lane_en,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] cell_q [WORDS];

        always_ff @(posedge clk) begin
            if (lane_en[k]) begin
                cell_q[waddr] <= wdata[k*LANE_W +: LANE_W];
            end
        end

        assign rdata[k*LANE_W +: LANE_W] = cell_q[raddr];
    end
endmodule

// File: rtl/fts_burst_ram.sv
module fts_burst_ram
    import fts_pkg::*;
#(
    parameter int WORDS  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int AW = $clog2(WORDS),
    localparam int DW = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_in,
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             en_a_n,
    input  logic             en_b,
    input  logic             en_c_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_n,
    input  logic [LANES-1:0] lane_sel_n,
    input  logic             step_n,
    input  logic             oe_n,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    ram_state_e st_q, st_d;

    logic          cpu_go, ctl_go, stb_go, en_ok;
    logic          load_go, desel_go, cont_go, adv_go, wr_go;
    logic [AW-1:0] cur_addr, waddr;
    logic [LANES-1:0] lane_en;

    // Strobe qualification: processor strobe needs the first enable
    assign cpu_go   = !cpu_strobe_n && !en_a_n;
    assign ctl_go   = !ctl_strobe_n;
    assign stb_go   = cpu_go || ctl_go;
    assign en_ok    = !en_a_n && en_b && !en_c_n;
    assign load_go  = stb_go && en_ok;
    assign desel_go = stb_go && !en_ok;
    assign cont_go  = !stb_go && (st_q != ST_DESEL);
    assign adv_go   = cont_go && !step_n;
    assign wr_go    = load_go || cont_go;
    assign waddr    = load_go ? addr_in : cur_addr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_DESEL;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_DESEL:  st_d = load_go ? ST_MASKED : ST_DESEL;
            ST_MASKED: st_d = desel_go ? ST_DESEL : ST_LIVE;
            ST_LIVE:   st_d = desel_go ? ST_DESEL : ST_LIVE;
            default:   st_d = ST_DESEL;
        endcase
    end

    // Outputs
    always_comb begin
        rvalid = 1'b0;
        unique case (st_q)
            ST_LIVE:  rvalid = !oe_n;
            default:  rvalid = 1'b0;
        endcase
    end

    fts_burst_addr #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_go   (load_go),
        .adv_go    (adv_go),
        .load_addr (addr_in),
        .cur_addr  (cur_addr)
    );

    fts_lane_decode #(.LANES(LANES)) u_lanes (
        .wr_go      (wr_go),
        .all_wr_n   (all_wr_n),
        .lane_wr_n  (lane_wr_n),
        .lane_sel_n (lane_sel_n),
        .lane_en    (lane_en)
    );

    fts_word_store #(.WORDS(WORDS), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .lane_en (lane_en),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr   (cur_addr),
        .rdata   (rdata)
    );
endmodule

// File: rtl/fts_burst_ram_chk.sv
module fts_burst_ram_chk
    import fts_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_strobe_n,
    input logic             ctl_strobe_n,
    input logic             en_a_n,
    input logic             en_b,
    input logic             en_c_n,
    input logic             all_wr_n,
    input logic             step_n,
    input logic             oe_n,
    input logic             rvalid,
    input ram_state_e       st_q,
    input logic [AW-1:0]    cur_addr,
    input logic [LANES-1:0] lane_en
);
    logic eff_stb, eff_en;
    assign eff_stb = (!cpu_strobe_n && !en_a_n) || !ctl_strobe_n;
    assign eff_en  = !en_a_n && en_b && !en_c_n;

    assert_oe_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !oe_n);

    assert_first_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DESEL && eff_stb && eff_en) |=> !rvalid);

    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_DESEL && !eff_stb && !step_n) |=>
        (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
        (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

    assert_cpu_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_a_n && ctl_strobe_n && step_n) |=> $stable(cur_addr));

    assert_desel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_stb && !eff_en) |=> !rvalid);

    assert_desel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DESEL && !eff_stb) |=> $stable(cur_addr));

    assert_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_wr_n && ((eff_stb && eff_en) || (!eff_stb && st_q != ST_DESEL)))
        |-> (lane_en == {LANES{1'b1}}));
endmodule

bind fts_burst_ram fts_burst_ram_chk #(.AW(AW), .LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .en_a_n       (en_a_n),
    .en_b         (en_b),
    .en_c_n       (en_c_n),
    .all_wr_n     (all_wr_n),
    .step_n       (step_n),
    .oe_n         (oe_n),
    .rvalid       (rvalid),
    .st_q         (st_q),
    .cur_addr     (cur_addr),
    .lane_en      (lane_en)
);

// File: tb/fts_burst_ram_test.sv
`timescale 1ns/1ps
module fts_burst_ram_test;
    localparam int AW = 6;
    localparam int NW = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic        cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1;
    logic        en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic        all_wr_n = 1'b1, lane_wr_n = 1'b1, step_n = 1'b1, oe_n = 1'b1;
    logic [3:0]  lane_sel_n = 4'hF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_chk = 0, n_bad = 0;

    // reference model state
    int          m_st = 0;          // 0 deselected, 1 first cycle, 2 live
    int          m_addr = 0;
    logic [31:0] m_mem [NW];
    logic [3:0]  m_known [NW];

    always #4 clk = ~clk;

    fts_burst_ram uut (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
        .step_n(step_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        logic ev;
        ev = (m_st == 2) && !oe_n;
        check(rvalid == ev, {tag, " rvalid"}, {31'd0, rvalid}, {31'd0, ev});
        if (ev && m_known[m_addr] == 4'hF)
            check(rdata == m_mem[m_addr], {tag, " rdata"}, rdata, m_mem[m_addr]);
    endtask

    task automatic model_edge();
        logic stb, en;
        logic [3:0] ln;
        int wa;
        stb = (!cpu_strobe_n && !en_a_n) || !ctl_strobe_n;
        en  = !en_a_n && en_b && !en_c_n;
        ln  = !all_wr_n ? 4'hF : (!lane_wr_n ? ~lane_sel_n : 4'h0);
        wa  = -1;
        if (stb && en) begin
            wa = int'(addr_in);
            m_addr = int'(addr_in);
            m_st = (m_st == 0) ? 1 : 2;
        end else if (stb) begin
            m_st = 0;
        end else if (m_st != 0) begin
            wa = m_addr;
            if (!step_n) m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
            m_st = 2;
        end
        if (wa >= 0) begin
            for (int k = 0; k < 4; k++) begin
                if (ln[k]) begin
                    m_mem[wa][k*8 +: 8] = wdata[k*8 +: 8];
                    m_known[wa][k] = 1'b1;
                end
            end
        end
    endtask

    task automatic step(input string tag);
        #2;
        compare(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        step_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin m_mem[i] = '0; m_known[i] = 4'h0; end
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        #2; compare("R11 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step("R11 after reset");

        // R7/R10: load 4, burst of global writes with stepping
        ctl_strobe_n = 1'b0; addr_in = 6'd4; oe_n = 1'b1;
        step("R1 load 4");
        idle(); all_wr_n = 1'b0; step_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            wdata = 32'hA0B0_0000 + 32'(i);
            step("R10 write+step");
        end
        idle();
        // read burst from 6 via processor strobe: 6,7,4,5,6
        cpu_strobe_n = 1'b0; addr_in = 6'd6; oe_n = 1'b0;
        step("R1 load 6");
        idle(); step_n = 1'b0;
        for (int i = 0; i < 5; i++) step("R7 wrap read");
        // R3: chip enables inactive without strobe do not stop burst
        en_b = 1'b0; en_c_n = 1'b1;
        step("R3 continue");
        step("R3 continue");
        idle();
        // R2: processor strobe with en_a_n high ignored
        cpu_strobe_n = 1'b0; en_a_n = 1'b1; addr_in = 6'd9;
        step("R2 ignored");
        idle();
        step("R2 after");
        // R4: deselect, step pulses ignored
        ctl_strobe_n = 1'b0; en_b = 1'b0;
        step("R4 deselect");
        idle(); step_n = 1'b0; all_wr_n = 1'b0; wdata = 32'hDEAD_BEEF;
        step("R4 quiet");
        step("R4 quiet");
        idle();
        // R9: load out of deselect, first cycle masked
        cpu_strobe_n = 1'b0; addr_in = 6'd5;
        step("R9 load");
        idle();
        step("R9 masked");
        step("R9 live");
        step_n = 1'b0;
        step("R4 no write landed");
        step("R4 no write landed");
        idle();
        // R5/R6 lane writes at 12
        oe_n = 1'b1;
        ctl_strobe_n = 1'b0; addr_in = 6'd12; all_wr_n = 1'b0; lane_wr_n = 1'b1;
        wdata = 32'h1122_3344;
        step("R5 global on load");
        idle(); lane_wr_n = 1'b0; lane_sel_n = 4'b0101; wdata = 32'hEEFF_CCDD;
        step("R6 lanes 1,3");
        idle(); lane_sel_n = 4'b0000; wdata = 32'h0;
        step("R6 no enable");
        idle(); oe_n = 1'b0;
        step("R6 readback");
        step("R6 readback");
        oe_n = 1'b1;
        all_wr_n = 1'b0; lane_wr_n = 1'b1; lane_sel_n = 4'hF; wdata = 32'h5566_7788;
        step("R5 global override");
        idle(); oe_n = 1'b0;
        step("R5 readback");
        // R8: output enable toggles asynchronously
        oe_n = 1'b1;
        step("R8 oe high");
        oe_n = 1'b0;
        step("R8 oe low");
        // R10: write on load edge uses new address
        oe_n = 1'b1;
        ctl_strobe_n = 1'b0; addr_in = 6'd21; all_wr_n = 1'b0; wdata = 32'hCAFE_0021;
        step("R10 write on load");
        idle(); oe_n = 1'b0;
        step("R10 readback");
        cpu_strobe_n = 1'b0; addr_in = 6'd4;
        step("R1 reload");
        idle(); step_n = 1'b0;
        for (int i = 0; i < 4; i++) step("R1 flow-through");
        idle();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule